// File: doc/BRIEF.md
# FIFO Event Interrupt Controller

This block collects the condition flags of a transmit FIFO and a receive FIFO, plus a word-transfer strobe, into one interrupt request line. Each direction offers six conditions: empty, almost-empty, full, almost-full, starve and overflow. A condition is noticed when it rises and is then held in a sticky status bit until software acknowledges it. Software acknowledges a bit by writing a 1 to the matching position of a write-only clear register.

A per-event enable register selects which sticky bits take part in the interrupt. A pending summary bit reports whether any enabled event is set. A master enable bit gates that summary onto the interrupt output, so software can poll pending with the output held quiet.

Register access is a single-cycle write strobe with an address and data. Reads are combinational from the same address.

Top module: `fifo_evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all status bits, all enable bits and the master enable are 0, and irq_o is 0.
- R2: A rising edge of receive flag i (rx_flags_i[i]) sets status bit i, and a rising edge of transmit flag i sets status bit 6+i. The flag index order is overflow 0, starve 1, almost-full 2, full 3, almost-empty 4, empty 5. So receive overflow is bit 0, receive empty is bit 5, transmit overflow is bit 6 and transmit empty is bit 11. The bit is visible after the same clock edge that samples the rise.
- R3: A flag that stays high sets its bit only once. After the bit is cleared, it stays 0 until the flag falls and rises again.
- R4: word_xfer_i high at a clock edge sets status bit 12. Every cycle it is high counts, not only its rising edge.
- R5: Writing to address 2 (clear) clears every status bit whose data bit is 1 and leaves status bits with a 0 data bit unchanged. The clear address reads as 0.
- R6: If a status bit is set and cleared at the same clock edge, the bit ends up set.
- R7: Address 0 (enable) is writable and readable. Bits 0 to 12 are per-event enables with the status bit layout, and bit 14 is the master enable. All other bits read 0.
- R8: Reading address 1 (status) returns the sticky bits in 0 to 12, and in bit 13 the pending summary (the OR of status AND enable over bits 0 to 12). The summary does not depend on the master enable.
- R9: irq_o equals the pending summary AND the master enable, and it follows the register state in the same cycle.
- R10: Status bits set on their conditions whether or not they are enabled. A write to address 1 or address 3 changes neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_flags_i | input | 6 | Receive FIFO condition levels (index order in R2) |
| tx_flags_i | input | 6 | Transmit FIFO condition levels (index order in R2) |
| word_xfer_i | input | 1 | Word-transfer strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 status, 2 clear, 3 spare |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can meet at the same clock edge: a new condition setting a status bit, and a software clear of that same bit. Directed steps raise a receive flag, a transmit flag and the word-transfer strobe while a clear with a 1 at that position is written in the same cycle. The bench expects the bit still set and the interrupt raised when the bit is enabled. The random phase toggles flags and issues clears and enable writes together, so this overlap recurs on many bits. A bench model that applies the clear first and then the set judges every cycle.

// File: rtl/fevt_pkg.sv
// Package: shared register address codes and event index layout for the
// FIFO event interrupt controller. Assumes a two-bit register address.
package fevt_pkg;

    localparam int FEVT_ADDR_W = 2;

    typedef enum logic [FEVT_ADDR_W-1:0] {
        ADR_ENABLE = 2'd0,
        ADR_STATUS = 2'd1,
        ADR_CLEAR  = 2'd2,
        ADR_SPARE  = 2'd3
    } fevt_addr_e;

    // index of each condition inside one direction's flag vector
    localparam int FLG_OVERFLOW = 0;
    localparam int FLG_STARVE   = 1;
    localparam int FLG_ALM_FULL = 2;
    localparam int FLG_FULL     = 3;
    localparam int FLG_ALM_EMPT = 4;
    localparam int FLG_EMPTY    = 5;

endpackage

// File: rtl/fevt_edge_detect.sv
// Module: fevt_edge_detect
// Turns a vector of level conditions into one-cycle rise strobes.
// Assumes conditions are synchronous to clk. The history register clears
// on reset, so a condition already high when reset ends counts as a rise.
module fevt_edge_detect #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] hist_q;

    // purpose: remember last cycle's level of each condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= level_i;
        end
    end

    // purpose: a rise is high now and low in the previous cycle
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_rise
            assign rise_o[gi] = level_i[gi] & ~hist_q[gi];
        end
    endgenerate

    // R3: after a rise is flagged, the same bit cannot flag again next cycle
    a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/fevt_status_bank.sv
// Module: fevt_status_bank
// Sticky event bits: set by set_i, cleared by write-one-to-clear clr_i.
// A set and a clear of the same bit in one cycle leaves the bit set.
// Assumes set_i and clr_i are single-cycle strobes on clk.
module fevt_status_bank #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] status_o
);

    logic [WIDTH-1:0] sticky_q;

    // purpose: per-bit sticky update, clear applied first and set on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= (sticky_q & ~clr_i) | set_i;
        end
    end

    assign status_o = sticky_q;

    // R6 / R2: any bit strobed by set_i is high after the edge
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R5: cleared bits without a concurrent set are low after the edge
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0));

    // R3: with no set and no clear, the status holds
    a_r3_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i | clr_i) == '0) |=> $stable(status_o));

endmodule

// File: rtl/fevt_regs.sv
// Module: fevt_regs
// Register window: enable register (per-event bits and master bit), status
// read view with pending summary, write-only clear register.
// Assumes single-cycle write strobes and combinational reads.
module fevt_regs
    import fevt_pkg::*;
#(
    parameter int NUM_EVT = 13,
    parameter int DATA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [FEVT_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [NUM_EVT-1:0]     status_i,
    input  logic                   pending_i,
    output logic [NUM_EVT-1:0]     evt_en_o,
    output logic                   master_en_o,
    output logic [NUM_EVT-1:0]     clr_o,
    output logic [DATA_W-1:0]      rdata_o
);

    localparam int PEND_BIT   = NUM_EVT;
    localparam int MASTER_BIT = NUM_EVT + 1;

    logic [NUM_EVT-1:0] en_q;
    logic               master_q;
    logic               wr_enable;
    logic               wr_clear;

    // purpose: decode which register a write targets
    always_comb begin
        wr_enable = wr_i && (fevt_addr_e'(addr_i) == ADR_ENABLE);
        wr_clear  = wr_i && (fevt_addr_e'(addr_i) == ADR_CLEAR);
    end

    // purpose: hold the per-event enables and master enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            master_q <= 1'b0;
        end else if (wr_enable) begin
            en_q     <= wdata_i[NUM_EVT-1:0];
            master_q <= wdata_i[MASTER_BIT];
        end
    end

    // purpose: form the one-cycle clear strobe from a clear write
    assign clr_o = wr_clear ? wdata_i[NUM_EVT-1:0] : '0;

    assign evt_en_o    = en_q;
    assign master_en_o = master_q;

    // purpose: combinational read view for the addressed register
    always_comb begin
        rdata_o = '0;
        case (fevt_addr_e'(addr_i))
            ADR_ENABLE: begin
                rdata_o[NUM_EVT-1:0] = en_q;
                rdata_o[MASTER_BIT]  = master_q;
            end
            ADR_STATUS: begin
                rdata_o[NUM_EVT-1:0] = status_i;
                rdata_o[PEND_BIT]    = pending_i;
            end
            default: rdata_o = '0;
        endcase
    end

    // R10: a write that is not to the enable address leaves the enables alone
    a_r10_enable_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i != ADR_ENABLE)) |=> ($stable(en_q) && $stable(master_q)));

    // R7: an enable write is reflected after the edge
    a_r7_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (en_q == $past(wdata_i[NUM_EVT-1:0])));

endmodule

// File: rtl/fevt_irq_combine.sv
// Module: fevt_irq_combine
// Reduces status AND enable to a pending summary and gates it with the
// master enable. Purely combinational; the request follows the registers.
module fevt_irq_combine #(
    parameter int NUM_EVT = 13
) (
    input  logic [NUM_EVT-1:0] status_i,
    input  logic [NUM_EVT-1:0] evt_en_i,
    input  logic               master_en_i,
    output logic               pending_o,
    output logic               irq_o
);

    // purpose: OR-reduce enabled events, then gate with master enable
    always_comb begin
        pending_o = |(status_i & evt_en_i);
        irq_o     = pending_o & master_en_i;
    end

endmodule

// File: rtl/fifo_evt_irq_ctrl.sv
// Module: fifo_evt_irq_ctrl (top)
// Gathers receive and transmit FIFO conditions and a word-transfer strobe
// into sticky status bits, and raises one interrupt request from them.
// Receive flags map to status bits 0..N-1, transmit flags to N..2N-1, and
// the word-transfer strobe to bit 2N. Assumes all inputs are on clk.
module fifo_evt_irq_ctrl
    import fevt_pkg::*;
#(
    parameter int N_FLAGS = 6,
    parameter int DATA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_FLAGS-1:0]     rx_flags_i,
    input  logic [N_FLAGS-1:0]     tx_flags_i,
    input  logic                   word_xfer_i,
    input  logic                   reg_wr_i,
    input  logic [FEVT_ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]      reg_wdata_i,
    output logic [DATA_W-1:0]      reg_rdata_o,
    output logic                   irq_o
);

    localparam int LVL_W   = 2 * N_FLAGS;
    localparam int NUM_EVT = LVL_W + 1;
    localparam int WX_BIT  = LVL_W;

    logic [LVL_W-1:0]   level_vec;
    logic [LVL_W-1:0]   rise_vec;
    logic [NUM_EVT-1:0] set_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] status_vec;
    logic [NUM_EVT-1:0] evt_en;
    logic               master_en;
    logic               pending;

    // purpose: pack receive flags low, transmit flags above them
    assign level_vec = {tx_flags_i, rx_flags_i};

    fevt_edge_detect #(.WIDTH(LVL_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_vec),
        .rise_o  (rise_vec)
    );

    // purpose: FIFO rises plus the word-transfer strobe, taken every cycle
    always_comb begin
        set_vec                = '0;
        set_vec[LVL_W-1:0]     = rise_vec;
        set_vec[WX_BIT]        = word_xfer_i;
    end

    fevt_status_bank #(.WIDTH(NUM_EVT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (status_vec)
    );

    fevt_regs #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .status_i    (status_vec),
        .pending_i   (pending),
        .evt_en_o    (evt_en),
        .master_en_o (master_en),
        .clr_o       (clr_vec),
        .rdata_o     (reg_rdata_o)
    );

    fevt_irq_combine #(.NUM_EVT(NUM_EVT)) u_irq (
        .status_i    (status_vec),
        .evt_en_i    (evt_en),
        .master_en_i (master_en),
        .pending_o   (pending),
        .irq_o       (irq_o)
    );

    // R9: no request without master enable and an enabled set event
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (master_en && ((status_vec & evt_en) != '0)));

    // R4: the word-transfer strobe always lands in its status bit
    a_r4_word_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        word_xfer_i |=> status_vec[WX_BIT]);

    // R1: the cycle after a reset edge, the request is low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

endmodule

// File: tb/tb_fifo_evt_irq_ctrl.sv
// Bench: directed corner cases plus seeded random stimulus, compared with a
// bench-side model of the register state built from the requirements.
module tb_fifo_evt_irq_ctrl;

    localparam int CLK_HALF = 10;   // 50 MHz
    localparam int NF       = 6;
    localparam int NE       = 13;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  rx_flags;
    logic [5:0]  tx_flags;
    logic        word_xfer;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    logic [12:0] m_status;
    logic [12:0] m_en;
    logic        m_master;
    logic [11:0] m_hist;

    always #(CLK_HALF) clk = ~clk;

    fifo_evt_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_flags_i  (rx_flags),
        .tx_flags_i  (tx_flags),
        .word_xfer_i (word_xfer),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    function automatic logic exp_pending();
        return |(m_status & m_en);
    endfunction

    function automatic logic [31:0] exp_status_word();
        logic [31:0] w;
        w        = '0;
        w[12:0]  = m_status;
        w[13]    = exp_pending();
        return w;
    endfunction

    function automatic logic [31:0] exp_enable_word();
        logic [31:0] w;
        w       = '0;
        w[12:0] = m_en;
        w[14]   = m_master;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus at the falling edge, update the model, pass the edge
    task automatic step(input logic [5:0] rx, input logic [5:0] tx, input logic wx,
                        input logic wr, input logic [1:0] ad, input logic [31:0] wd);
        logic [11:0] lvl;
        logic [12:0] setv;
        logic [12:0] clrv;
        @(negedge clk);
        rx_flags  = rx;
        tx_flags  = tx;
        word_xfer = wx;
        reg_wr    = wr;
        reg_addr  = ad;
        reg_wdata = wd;
        lvl        = {tx, rx};
        setv       = {wx, lvl & ~m_hist};
        clrv       = (wr && ad == 2'd2) ? wd[12:0] : 13'd0;
        m_status   = (m_status & ~clrv) | setv;
        m_hist     = lvl;
        if (wr && ad == 2'd0) begin
            m_en     = wd[12:0];
            m_master = wd[14];
        end
        @(posedge clk);
        #2;
        reg_wr    = 1'b0;
        word_xfer = 1'b0;
    endtask

    task automatic check_all(input string req);
        reg_addr = 2'd1;
        #1;
        check({req, " status"}, reg_rdata, exp_status_word());
        check({req, " irq"}, {31'd0, irq}, {31'd0, exp_pending() & m_master});
        reg_addr = 2'd0;
        #1;
        check({req, " enable"}, reg_rdata, exp_enable_word());
    endtask

    // watchdog
    initial begin
        #(CLK_HALF * 2 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; rx_flags = '0; tx_flags = '0; word_xfer = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_status = '0; m_en = '0; m_master = 1'b0; m_hist = '0;
        repeat (3) @(posedge clk);
        #2;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R7: enable register readback, reserved bits read 0
        step('0, '0, 0, 1, 2'd0, 32'hFFFF_FFFF);
        check_all("R7 enable all ones");
        step('0, '0, 0, 1, 2'd0, 32'h0000_0000);
        check_all("R7 enable zero");

        // R10: events latch while disabled; R2 receive overflow at bit 0
        step(6'b000001, '0, 0, 0, 2'd1, 0);
        check_all("R2 R10 rx overflow bit0 disabled");
        check("R2 rx overflow bit0", {31'd0, reg_rdata[0]}, 32'd0); // enable view bit0
        // R2: transmit empty at bit 11
        step(6'b000001, 6'b100000, 0, 0, 2'd1, 0);
        check_all("R2 tx empty bit11");
        // R8: pending shows without master; R9: no irq
        step(6'b000001, 6'b100000, 0, 1, 2'd0, 32'h0000_0800);
        check_all("R8 pending without master");
        // R9: master on raises irq
        step(6'b000001, 6'b100000, 0, 1, 2'd0, 32'h0000_4800);
        check_all("R9 irq with master");
        // R5: clear bit 11 only, bit 0 stays
        step(6'b000001, 6'b100000, 0, 1, 2'd2, 32'h0000_0800);
        check_all("R5 clear bit11");
        // R3: flag held high does not re-set bit 11
        step(6'b000001, 6'b100000, 0, 0, 2'd1, 0);
        check_all("R3 held level no reset");
        // R5: clear address reads 0
        reg_addr = 2'd2; #1;
        check("R5 clear reads zero", reg_rdata, 32'd0);
        // R10: write to status and spare addresses does nothing
        step(6'b000001, 6'b100000, 0, 1, 2'd1, 32'hFFFF_FFFF);
        check_all("R10 status write ignored");
        step(6'b000001, 6'b100000, 0, 1, 2'd3, 32'hFFFF_FFFF);
        check_all("R10 spare write ignored");
        // R6: drop flags, then rise with a same-cycle clear
        step('0, '0, 0, 1, 2'd2, 32'h0000_1FFF);
        check_all("R5 clear all");
        step(6'b001000, 6'b000010, 1, 1, 2'd2, 32'h0000_1FFF);
        check_all("R6 set wins over clear");
        // R4: word transfer on consecutive cycles, each cycle counts
        step('0, '0, 1, 1, 2'd2, 32'h0000_1FFF);
        check_all("R4 word xfer repeat with clear");
        step('0, '0, 0, 1, 2'd0, 32'h0000_5000);
        check_all("R4 word xfer enabled irq");

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [5:0]  rx;
            logic [5:0]  tx;
            logic        wx;
            logic        wr;
            logic [1:0]  ad;
            logic [31:0] wd;
            int          op;
            rx = rx_flags;
            tx = tx_flags;
            for (int b = 0; b < NF; b++) begin
                if (($urandom % 8) == 0) rx[b] = ~rx[b];
                if (($urandom % 8) == 0) tx[b] = ~tx[b];
            end
            wx = (($urandom % 6) == 0);
            op = $urandom % 10;
            wd = $urandom;
            wr = (op < 6);
            ad = (op < 2) ? 2'd0 : (op < 5) ? 2'd2 : (op == 5) ? 2'd1 : 2'd0;
            step(rx, tx, wx, wr, ad, wd);
            check_all("R2 R5 R6 R8 R9 random");
        end

        rst_n = 1'b0;
        step('0, '0, 0, 0, 2'd0, 0);
        m_status = '0; m_en = '0; m_master = 1'b0; m_hist = '0;
        check_all("R1 reset again");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule